// File: doc/BRIEF.md
# Absolute Position Frame Serializer

This block takes a snapshot of an encoder position and sends it out as one serial frame of variable length. The frame holds these fields, always in this sequence: a multiturn revolution count, a singleturn coarse period count, fine interpolated position bits, an error flag, a warning flag, a sign-of-life counter, and a check code. Configuration inputs set the length of each field. Any field before the check code can be set to zero length, which removes it from the frame.

A one-cycle latch pulse, given while the block is idle, captures the position inputs and advances the sign-of-life counter. The packed frame is then presented MSB first on a single data output. The output moves to the next bit on every cycle in which the shift enable is high. A last-bit flag marks the final bit. The check code is computed over the data bits while they are shifted out, and it is sent inverted. The protocol layer around this block supplies the shift enables and any start or acknowledge bits.

Top module: `pos_frame_ser`

## Requirements
- R1: After reset `busy`, `sdo` and `sdo_last` are 0, and the sign-of-life counter is 0. The first accepted latch therefore sends the value 1.
- R2: The data fields are sent in this sequence: revolution count, period count, fine position, error, warning, sign-of-life. Each field is sent MSB first. Only the low bits of each input that fit the programmed field length are sent.
- R3: The revolution count length equals `cfg_rev_len` (0 to 40 bits). Codes above 40 are treated as 40.
- R4: `cfg_per_len` sets the period count length: 0 gives 0 bits, 1 gives 8 bits, 2 gives 16 bits, and 3 gives 0 bits.
- R5: `cfg_fine_len` codes 0 to 6 give a fine position field of that many bits. Code 7 gives 0 bits.
- R6: When `cfg_fine_full` is 0, only `in_fine[2:0]` is valid. The field keeps its programmed length, its value is right-aligned, and every higher bit is sent as 0.
- R7: The error and warning bits are each present only when their enable is 1. Each is sent active low, so the bit on the line is the inverse of `in_err` or `in_warn`.
- R8: The 6-bit sign-of-life field is present when `cfg_sol_en` is 1. The counter advances on every accepted latch, including when the field is disabled. It counts 1, 2, …, 63 and then wraps to 1, never returning to 0.
- R9: The check code is 6 bits when `cfg_crc_wide` is 0 and 16 bits when it is 1.
  - The 6-bit code uses polynomial x^6+x+1 and the 16-bit code uses 0x1021.
  - Both start from zero, are computed MSB first over all data bits of the frame, and are sent bit-inverted, MSB first.
- R10: When `cfg_if_mode` equals 2, no check code is appended.
- R11: `sdo_last` is high exactly while the final bit of the frame is on `sdo`. The shift that consumes the final bit returns `busy` to 0.
- R12: A latch pulse while `busy` is 1 is ignored. The frame in progress is unchanged and the sign-of-life counter does not advance.
- R13: While `busy` is 1 and `shift_en` is 0, `sdo` holds its value and the frame does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rev_len | input | 6 | Revolution count length in bits (0 to 40, larger values clamp to 40) |
| cfg_per_len | input | 2 | Period count length select (0/8/16 bits, 3 gives 0) |
| cfg_fine_len | input | 3 | Fine position length in bits (7 gives 0) |
| cfg_fine_full | input | 1 | 1: six valid fine bits; 0: only three valid fine bits |
| cfg_err_en | input | 1 | Include the error bit |
| cfg_warn_en | input | 1 | Include the warning bit |
| cfg_sol_en | input | 1 | Include the 6-bit sign-of-life field |
| cfg_crc_wide | input | 1 | 0: 6-bit check code; 1: 16-bit check code |
| cfg_if_mode | input | 2 | Interface mode; value 2 drops the check code |
| in_rev | input | 40 | Revolution count |
| in_per | input | 16 | Period count |
| in_fine | input | 6 | Interpolated fine position |
| in_err | input | 1 | Error condition, active high at the input |
| in_warn | input | 1 | Warning condition, active high at the input |
| latch | input | 1 | Snapshot strobe |
| shift_en | input | 1 | Advance to the next frame bit |
| sdo | output | 1 | Serial data, current frame bit |
| sdo_last | output | 1 | Current bit is the final frame bit |
| busy | output | 1 | A frame is in progress |

## Verification
A wrong length counter, or a wrong left alignment of the packed word, moves every later field. It shows up on `sdo` at the first misplaced bit, and it also moves `sdo_last` and the fall of `busy` by the same number of cycles. A corrupted check code register stays hidden through the data bits and appears only in the final 6 or 16 bits. A sign-of-life counter that skips or repeats a value only appears in the next frame that carries the field. For that reason the bench runs a chain of short frames past the wrap from 63 to 1.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int REV_MAX    = 40;
    localparam int PER_MAX    = 16;
    localparam int FINE_MAX   = 6;
    localparam int FINE_BASIC = 3;
    localparam int SOL_W      = 6;
    localparam int CRC_NARROW = 6;
    localparam int CRC_WIDE   = 16;
    localparam int DATA_W     = REV_MAX + PER_MAX + FINE_MAX + 2 + SOL_W;
    localparam int LEN_W      = $clog2(DATA_W + 1);
    localparam int CCNT_W     = $clog2(CRC_WIDE + 1);

    localparam logic [CRC_NARROW-1:0] POLY_NARROW = 6'h03;
    localparam logic [CRC_WIDE-1:0]   POLY_WIDE   = 16'h1021;
    localparam logic [1:0]            MODE_NO_CRC = 2'd2;

    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t bits;   // left-aligned frame data
        len_t  len;    // number of valid data bits
    } frame_t;

    typedef enum logic [1:0] {
        PER_NONE = 2'd0,
        PER_8    = 2'd1,
        PER_16   = 2'd2,
        PER_RSVD = 2'd3
    } per_sel_e;

    function automatic len_t rev_len(input logic [5:0] code);
        return (int'(code) > REV_MAX) ? len_t'(REV_MAX) : len_t'(code);
    endfunction

    function automatic len_t per_len(input logic [1:0] code);
        case (per_sel_e'(code))
            PER_8:   return len_t'(8);
            PER_16:  return len_t'(16);
            default: return '0;
        endcase
    endfunction

    function automatic len_t fine_len(input logic [2:0] code);
        return (int'(code) > FINE_MAX) ? '0 : len_t'(code);
    endfunction

    function automatic word_t low_mask(input len_t n);
        return ~({DATA_W{1'b1}} << n);
    endfunction

    function automatic logic [CCNT_W-1:0] crc_len(input logic [1:0] mode, input logic wide);
        if (mode == MODE_NO_CRC) return '0;
        return wide ? CCNT_W'(CRC_WIDE) : CCNT_W'(CRC_NARROW);
    endfunction

endpackage

// File: rtl/pfs_pack.sv
module pfs_pack
    import pfs_pkg::*;
(
    input  logic [5:0]          rev_code,
    input  logic [1:0]          per_code,
    input  logic [2:0]          fine_code,
    input  logic                fine_full,
    input  logic                err_en,
    input  logic                warn_en,
    input  logic                sol_en,
    input  logic [REV_MAX-1:0]  rev,
    input  logic [PER_MAX-1:0]  per,
    input  logic [FINE_MAX-1:0] fine,
    input  logic                err,
    input  logic                warn,
    input  logic [SOL_W-1:0]    sol,
    output frame_t              frame
);

    localparam logic [FINE_MAX-1:0] FINE_BASIC_MASK = FINE_MAX'((1 << FINE_BASIC) - 1);

    len_t                rl, pl, fl, total;
    word_t               acc;
    logic [FINE_MAX-1:0] fine_v;

    always_comb begin
        rl     = rev_len(rev_code);
        pl     = per_len(per_code);
        fl     = fine_len(fine_code);
        fine_v = fine & (fine_full ? {FINE_MAX{1'b1}} : FINE_BASIC_MASK);

        acc = '0;
        acc = (acc << rl) | (word_t'(rev)    & low_mask(rl));
        acc = (acc << pl) | (word_t'(per)    & low_mask(pl));
        acc = (acc << fl) | (word_t'(fine_v) & low_mask(fl));
        if (err_en)  acc = {acc[DATA_W-2:0], ~err};
        if (warn_en) acc = {acc[DATA_W-2:0], ~warn};
        if (sol_en)  acc = (acc << SOL_W) | word_t'(sol);

        total = rl + pl + fl + len_t'(err_en) + len_t'(warn_en)
              + (sol_en ? len_t'(SOL_W) : '0);

        frame.len  = total;
        frame.bits = acc << (len_t'(DATA_W) - total);
    end

endmodule

// File: rtl/pfs_crc.sv
module pfs_crc #(
    parameter int           W    = 6,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic shf,
    input  logic din,
    output logic msb
);

    logic [W-1:0] r;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            r <= '0;
        end else if (upd) begin
            r <= {r[W-2:0], 1'b0} ^ ((din ^ r[W-1]) ? POLY : '0);
        end else if (shf) begin
            r <= {r[W-2:0], 1'b0};
        end
    end

    assign msb = r[W-1];

endmodule

// File: rtl/pfs_sol.sv
module pfs_sol
    import pfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [SOL_W-1:0] cur,
    output logic [SOL_W-1:0] nxt
);

    always_comb begin
        nxt = (cur == {SOL_W{1'b1}}) ? SOL_W'(1) : cur + SOL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)      cur <= '0;
        else if (adv) cur <= nxt;
    end

endmodule

// File: rtl/pos_frame_ser.sv
module pos_frame_ser
    import pfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  cfg_rev_len,
    input  logic [1:0]  cfg_per_len,
    input  logic [2:0]  cfg_fine_len,
    input  logic        cfg_fine_full,
    input  logic        cfg_err_en,
    input  logic        cfg_warn_en,
    input  logic        cfg_sol_en,
    input  logic        cfg_crc_wide,
    input  logic [1:0]  cfg_if_mode,
    input  logic [39:0] in_rev,
    input  logic [15:0] in_per,
    input  logic [5:0]  in_fine,
    input  logic        in_err,
    input  logic        in_warn,
    input  logic        latch,
    input  logic        shift_en,
    output logic        sdo,
    output logic        sdo_last,
    output logic        busy
);

    frame_t            frm;
    word_t             shreg;
    len_t              dcnt;
    logic [CCNT_W-1:0] ccnt;
    logic              wide_q;
    logic              in_data, accept, step;
    logic [SOL_W-1:0]  sol_q, sol_nxt;
    logic              crc_msb_n, crc_msb_w, crc_msb;

    pfs_sol u_sol (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .cur (sol_q),
        .nxt (sol_nxt)
    );

    pfs_pack u_pack (
        .rev_code  (cfg_rev_len),
        .per_code  (cfg_per_len),
        .fine_code (cfg_fine_len),
        .fine_full (cfg_fine_full),
        .err_en    (cfg_err_en),
        .warn_en   (cfg_warn_en),
        .sol_en    (cfg_sol_en),
        .rev       (in_rev),
        .per       (in_per),
        .fine      (in_fine),
        .err       (in_err),
        .warn      (in_warn),
        .sol       (sol_nxt),
        .frame     (frm)
    );

    assign in_data = (dcnt != '0);
    assign busy    = in_data || (ccnt != '0);
    assign accept  = latch && !busy;
    assign step    = shift_en && busy;

    pfs_crc #(.W(CRC_NARROW), .POLY(POLY_NARROW)) u_crc_n (
        .clk (clk),
        .rst (rst),
        .clr (accept),
        .upd (step && in_data),
        .shf (step && !in_data),
        .din (shreg[DATA_W-1]),
        .msb (crc_msb_n)
    );

    pfs_crc #(.W(CRC_WIDE), .POLY(POLY_WIDE)) u_crc_w (
        .clk (clk),
        .rst (rst),
        .clr (accept),
        .upd (step && in_data),
        .shf (step && !in_data),
        .din (shreg[DATA_W-1]),
        .msb (crc_msb_w)
    );

    assign crc_msb = wide_q ? crc_msb_w : crc_msb_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            dcnt   <= '0;
            ccnt   <= '0;
            wide_q <= 1'b0;
        end else if (accept) begin
            shreg  <= frm.bits;
            dcnt   <= frm.len;
            ccnt   <= crc_len(cfg_if_mode, cfg_crc_wide);
            wide_q <= cfg_crc_wide;
        end else if (step) begin
            if (in_data) begin
                shreg <= {shreg[DATA_W-2:0], 1'b0};
                dcnt  <= dcnt - len_t'(1);
            end else begin
                ccnt  <= ccnt - CCNT_W'(1);
            end
        end
    end

    always_comb begin
        if (in_data)          sdo = shreg[DATA_W-1];
        else if (ccnt != '0)  sdo = ~crc_msb;
        else                  sdo = 1'b0;
        sdo_last = ((dcnt == len_t'(1)) && (ccnt == '0))
                || ((dcnt == '0) && (ccnt == CCNT_W'(1)));
    end

endmodule

// File: rtl/pfs_check.sv
module pfs_check (
    input logic       clk,
    input logic       rst,
    input logic       latch,
    input logic       shift_en,
    input logic       busy,
    input logic       sdo,
    input logic       sdo_last,
    input logic [5:0] sol_q
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sdo && !sdo_last));

    p_last_in_frame_r11: assert property (@(posedge clk) disable iff (rst)
        sdo_last |-> busy);

    p_last_ends_r11: assert property (@(posedge clk) disable iff (rst)
        (sdo_last && shift_en) |=> !busy);

    p_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (busy && !shift_en) |=> (busy && $stable(sdo) && $stable(sdo_last)));

    p_strobe_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && latch) |=> $stable(sol_q));

    p_sol_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (sol_q != 6'd0) |=> (sol_q != 6'd0));

endmodule

bind pos_frame_ser pfs_check u_chk (
    .clk      (clk),
    .rst      (rst),
    .latch    (latch),
    .shift_en (shift_en),
    .busy     (busy),
    .sdo      (sdo),
    .sdo_last (sdo_last),
    .sol_q    (sol_q)
);

// File: tb/pos_frame_ser_test.sv
module pos_frame_ser_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_rev_len = 6'd16;
    logic [1:0]  cfg_per_len = 2'd1;
    logic [2:0]  cfg_fine_len = 3'd3;
    logic        cfg_fine_full = 1'b1;
    logic        cfg_err_en = 1'b1;
    logic        cfg_warn_en = 1'b1;
    logic        cfg_sol_en = 1'b1;
    logic        cfg_crc_wide = 1'b0;
    logic [1:0]  cfg_if_mode = 2'd0;
    logic [39:0] in_rev = '0;
    logic [15:0] in_per = '0;
    logic [5:0]  in_fine = '0;
    logic        in_err = 1'b0;
    logic        in_warn = 1'b0;
    logic        latch = 1'b0;
    logic        shift_en = 1'b0;
    logic        sdo, sdo_last, busy;

    int    n_checks = 0;
    int    n_fail = 0;
    logic  exp_q[$];
    string cur_req = "R1";
    int    sol_m = 0;
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pos_frame_ser uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && busy) begin
            if (exp_q.size() == 0) begin
                check({cur_req, " extra bit"}, 64'(1), 64'(0));
            end else begin
                check({cur_req, " sdo"}, 64'(sdo), 64'(exp_q[0]));
                check({cur_req, " R11 last"}, 64'(sdo_last), 64'(exp_q.size() == 1));
                if (shift_en) void'(exp_q.pop_front());
            end
        end
    end

    task automatic push_frame();
        logic d[$];
        int rl, pl, fl, w;
        logic [15:0] c, poly;
        logic [5:0] fv;
        logic fb;
        sol_m = (sol_m == 63) ? 1 : sol_m + 1;
        rl = (int'(cfg_rev_len) > 40) ? 40 : int'(cfg_rev_len);
        pl = (cfg_per_len == 2'd1) ? 8 : (cfg_per_len == 2'd2) ? 16 : 0;
        fl = (cfg_fine_len == 3'd7) ? 0 : int'(cfg_fine_len);
        fv = cfg_fine_full ? in_fine : (in_fine & 6'h07);
        for (int i = rl - 1; i >= 0; i--) d.push_back(in_rev[i]);
        for (int i = pl - 1; i >= 0; i--) d.push_back(in_per[i]);
        for (int i = fl - 1; i >= 0; i--) d.push_back(fv[i]);
        if (cfg_err_en)  d.push_back(~in_err);
        if (cfg_warn_en) d.push_back(~in_warn);
        if (cfg_sol_en) for (int i = 5; i >= 0; i--) d.push_back(sol_m[i]);
        foreach (d[i]) exp_q.push_back(d[i]);
        if (cfg_if_mode != 2'd2) begin
            w    = cfg_crc_wide ? 16 : 6;
            poly = cfg_crc_wide ? 16'h1021 : 16'h0003;
            c    = '0;
            foreach (d[i]) begin
                fb = d[i] ^ c[w-1];
                c  = c << 1;
                if (fb) c = c ^ poly;
            end
            for (int i = w - 1; i >= 0; i--) exp_q.push_back(~c[i]);
        end
    endtask

    // driver: pause_at < 0 means no pause; during a pause a strobe with new data is sent
    task automatic run_frame(input string req, input int pause_at);
        int n;
        @(posedge clk); #1;
        cur_req = req;
        push_frame();
        latch = 1'b1;
        @(posedge clk); #1;
        latch = 1'b0;
        shift_en = 1'b1;
        n = 0;
        while (busy) begin
            if (n == pause_at) begin
                shift_en = 1'b0;
                in_rev  = ~in_rev;
                in_fine = ~in_fine;
                latch = 1'b1;
                @(posedge clk); #1;
                latch = 1'b0;
                @(posedge clk); #1;
                @(posedge clk); #1;
                shift_en = 1'b1;
            end
            @(posedge clk); #1;
            n++;
        end
        shift_en = 1'b0;
        check({req, " R11 frame complete"}, 64'(exp_q.size()), 64'(0));
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 busy", 64'(busy), 64'(0));
        check("R1 sdo", 64'(sdo), 64'(0));
        check("R1 sdo_last", 64'(sdo_last), 64'(0));

        // R1/R2/R9: default-like layout, first frame carries sign-of-life 1, 6-bit code
        in_rev = 40'h00_0000_A5C3; in_per = 16'h005A; in_fine = 6'h05;
        in_err = 1'b0; in_warn = 1'b1;
        run_frame("R1/R2/R9 default", -1);

        // R3/R9: full widths, 16-bit code
        cfg_rev_len = 6'd40; cfg_per_len = 2'd2; cfg_fine_len = 3'd6; cfg_crc_wide = 1'b1;
        in_rev = 40'hC3_9A5F_1E27; in_per = 16'hB4E1; in_fine = 6'h2D; in_err = 1'b1;
        run_frame("R3/R9 full", -1);

        // R3/R4/R5: clamped rev code, reserved period and fine codes
        cfg_rev_len = 6'd45; cfg_per_len = 2'd3; cfg_fine_len = 3'd7; cfg_crc_wide = 1'b0;
        run_frame("R3/R4/R5 reserved codes", -1);

        // R6: three valid fine bits in a 6-bit field
        cfg_rev_len = 6'd5; cfg_per_len = 2'd1; cfg_fine_len = 3'd6; cfg_fine_full = 1'b0;
        in_fine = 6'h3E;
        run_frame("R6 fine basic", -1);
        cfg_fine_len = 3'd2;
        run_frame("R6 fine short", -1);
        cfg_fine_full = 1'b1;

        // R10: no check code
        cfg_if_mode = 2'd2;
        run_frame("R10 no crc", -1);
        cfg_if_mode = 2'd1;

        // R7: only flags and check code
        cfg_rev_len = 6'd0; cfg_per_len = 2'd0; cfg_fine_len = 3'd0; cfg_sol_en = 1'b0;
        in_err = 1'b1; in_warn = 1'b0;
        run_frame("R7 flags", -1);
        cfg_err_en = 1'b0;
        run_frame("R7 warn only", -1);
        cfg_err_en = 1'b1; cfg_sol_en = 1'b1;

        // R12/R13: pause mid-frame with an ignored strobe, then check next frame's sign-of-life
        cfg_rev_len = 6'd12; cfg_per_len = 2'd1; cfg_fine_len = 3'd4; cfg_crc_wide = 1'b1;
        run_frame("R12/R13 pause", 7);
        run_frame("R12 after ignored strobe", -1);

        // R8: wrap past 63
        cfg_rev_len = 6'd0; cfg_per_len = 2'd0; cfg_fine_len = 3'd0;
        cfg_err_en = 1'b0; cfg_warn_en = 1'b0; cfg_if_mode = 2'd2;
        for (int k = 0; k < 66; k++) run_frame("R8 sol wrap", -1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule